// File: doc/BRIEF.md
# Touch Pen Contact Debouncer

This block watches the raw contact indication of a resistive touch panel, a level that arrives with no relation to the system clock. It brings that level into the clock domain and filters it. It keeps a confirmed view of the pen: unknown after reset, then up or down. The confirmed view changes only after the synchronized level has held steady for longer than a programmed debounce length. That length is 2^N clock cycles, and N is a small field that software programs.

Each change of the confirmed view records an event in a sticky status bit. There is one bit for "pen down" and one for "pen up". A bit stays set until the status is read, and the read clears both bits. Two enable bits pick which of the sticky bits drive the single interrupt line. An enable can also route a fresh pen-down confirmation to a one-cycle pulse that starts a position conversion, so the panel is measured as soon as contact is known.

Top module: `pen_dbnc_top`

## Requirements
- R1: While reset is asserted, `stat_o` is 2'b00 and both `irq_o` and `conv_start_o` are 0.
- R2: `stat_o[0]` (pen down) becomes 1 when the synchronized contact level has been 1 for L+1 consecutive cycles and the confirmed view was not already down. L = 2^N and N = `dbnc_exp_i`. The bit is visible at the rising edge L+3 edges after the first edge that samples the raw 1.
- R3: `stat_o[1]` (pen up) becomes 1 under the same rule and timing when the level has been 0 for L+1 cycles and the confirmed view was not already up.
- R4: A level that holds for only L cycles before returning to the confirmed value records no event.
- R5: Both status bits stay set until a read. While `stat_rd_i` is 1, `stat_o` shows the bits before clearing, and the edge that closes that cycle clears both bits.
- R6: If an event occurs at the same edge that closes a read cycle, that event's bit is 1 afterwards. The other bit is cleared.
- R7: `irq_o` is 1 exactly when (`stat_o[0]` and `irq_en_i[0]`) or (`stat_o[1]` and `irq_en_i[1]`).
- R8: `conv_start_o` is a one-cycle pulse. It rises at the same edge that sets the pen-down bit, and only when `conv_en_i` is 1. No pulse comes from a pen-up event or while contact merely continues.
- R9: After reset the confirmed view is unknown, so the first stable level of either value records its event.
- R10: Holding a level that is already confirmed records nothing more after the status has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Debounce and system clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pen_raw_i | input | 1 | Raw contact level from the panel, asynchronous |
| dbnc_exp_i | input | EXP_W | Debounce exponent N; the length is 2^N cycles |
| irq_en_i | input | 2 | Interrupt enables: bit 0 pen down, bit 1 pen up |
| conv_en_i | input | 1 | Route pen-down confirmation to a conversion start |
| stat_rd_i | input | 1 | Status read strobe; clears both bits at the edge that closes the read cycle |
| stat_o | output | 2 | Sticky status: bit 0 pen down, bit 1 pen up |
| irq_o | output | 1 | Interrupt request |
| conv_start_o | output | 1 | One-cycle conversion start pulse |

## Verification
A raw change that is driven on a falling edge is first sampled by the next rising edge. Its status bit, and any conversion pulse, are due at the rising edge L+3 edges later. The bench counts rising edges, computes that due count for every stimulus and queues it with the event kind. A monitor compares each rising status bit and each pulse it observes against the head of the queue, checking both the kind and the cycle. Status and interrupt are read on falling edges. A read clears the bits at the edge that closes the read cycle, so the cleared value is checked one falling edge later. The case of an event that coincides with a read is arranged by asserting the strobe in the cycle before the event's due edge.

// File: rtl/pen_dbnc_pkg.sv
package pen_dbnc_pkg;

  // Confirmed pen view kept by the filter.
  typedef enum logic [1:0] {
    PEN_UNK  = 2'd0,
    PEN_UP   = 2'd1,
    PEN_DOWN = 2'd2
  } pen_state_e;

  // Event vector; packed so that bit 0 is pen down and bit 1 is pen up.
  typedef struct packed {
    logic up;
    logic down;
  } pen_evt_t;

endpackage

// File: rtl/pen_dbnc_sync.sv
module pen_dbnc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[0] <= 1'b0;
        else         sh_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[i] <= 1'b0;
        else         sh_q[i] <= sh_q[i-1];
      end
    end
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/pen_dbnc_filter.sv
module pen_dbnc_filter
  import pen_dbnc_pkg::*;
#(
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic [EXP_W-1:0] exp_i,
  output pen_evt_t         evt_o
);

  // Largest length is 2^(2^EXP_W - 1); this width holds it.
  localparam int unsigned CNT_W = 1 << EXP_W;

  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] limit;
  logic             chg, held;
  pen_state_e       state_q, state_d;
  pen_evt_t         fire;

  assign limit = CNT_W'(1) << exp_i;
  assign chg   = lvl_i ^ lvl_q;
  assign held  = (cnt_q >= limit);

  // Level follower for the change detector.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  // Stability counter: restarts on a change, saturates at the limit.
  always_comb begin
    cnt_en = chg | (cnt_q < limit);
    cnt_d  = chg ? '0 : (cnt_q + CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Confirmed view and the event that its change raises.
  always_comb begin
    fire.down = held &  lvl_q & (state_q != PEN_DOWN);
    fire.up   = held & ~lvl_q & (state_q != PEN_UP);
    state_d   = state_q;
    if (fire.down)    state_d = PEN_DOWN;
    else if (fire.up) state_d = PEN_UP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  state_q <= PEN_UNK;
    else if (fire.down | fire.up) state_q <= state_d;
  end

  assign evt_o = fire;

  // R2: entering the down view needs the level to have been high.
  p_down_needs_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PEN_DOWN && $past(state_q) != PEN_DOWN) |-> $past(lvl_q));

  // R3: entering the up view needs the level to have been low.
  p_up_needs_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PEN_UP && $past(state_q) != PEN_UP) |-> !$past(lvl_q));

  // R4: every level change restarts the stability count.
  p_restart_on_change_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> (cnt_q == '0));

  // R10: the view never leaves a state once the level holds it.
  p_hold_keeps_view_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PEN_DOWN && lvl_q && lvl_i) |=> (state_q == PEN_DOWN));

endmodule

// File: rtl/pen_dbnc_evt.sv
module pen_dbnc_evt
  import pen_dbnc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pen_evt_t   evt_i,
  input  logic       rd_i,
  input  logic [1:0] irq_en_i,
  input  logic       conv_en_i,
  output logic [1:0] stat_o,
  output logic       irq_o,
  output logic       conv_o
);

  pen_evt_t bits_q, bits_d;
  logic     bits_en;
  logic     conv_q, conv_d;

  // Sticky bits: a new event outranks the read clear.
  always_comb begin
    bits_en     = evt_i.down | evt_i.up | rd_i;
    bits_d.down = evt_i.down | (bits_q.down & ~rd_i);
    bits_d.up   = evt_i.up   | (bits_q.up   & ~rd_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bits_q <= '0;
    else if (bits_en) bits_q <= bits_d;
  end

  // Conversion start: registered so it lines up with the status bit.
  always_comb conv_d = evt_i.down & conv_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conv_q <= 1'b0;
    else         conv_q <= conv_d;
  end

  assign stat_o = bits_q;
  assign irq_o  = |(bits_q & irq_en_i);
  assign conv_o = conv_q;

  // R5: a set bit survives any cycle without a read.
  p_sticky_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bits_q.down && !rd_i) |=> bits_q.down);

  // R5: a read with no new event leaves the bit clear.
  p_read_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !evt_i.up) |=> !bits_q.up);

  // R6: an event is never lost to a coincident read.
  p_event_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.up |=> bits_q.up);

  // R8: the conversion start never lasts two cycles.
  p_conv_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |=> !conv_o);

  // R8: the pulse coincides with a freshly set pen-down bit.
  p_conv_with_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> bits_q.down);

  // R7: no interrupt without some status bit.
  p_irq_needs_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_o != 2'b00));

endmodule

// File: rtl/pen_dbnc_top.sv
module pen_dbnc_top
  import pen_dbnc_pkg::*;
#(
  parameter int unsigned EXP_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pen_raw_i,
  input  logic [EXP_W-1:0] dbnc_exp_i,
  input  logic [1:0]       irq_en_i,
  input  logic             conv_en_i,
  input  logic             stat_rd_i,
  output logic [1:0]       stat_o,
  output logic             irq_o,
  output logic             conv_start_o
);

  logic     rst_n;
  logic     pen_sync;
  pen_evt_t evt;

  // Reset asserts at once and is released on a clock edge.
  pen_dbnc_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_n)
  );

  pen_dbnc_sync #(.STAGES(SYNC_STAGES)) u_pen_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (pen_raw_i),
    .q_o   (pen_sync)
  );

  pen_dbnc_filter #(.EXP_W(EXP_W)) u_filter (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .lvl_i (pen_sync),
    .exp_i (dbnc_exp_i),
    .evt_o (evt)
  );

  pen_dbnc_evt u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .evt_i    (evt),
    .rd_i     (stat_rd_i),
    .irq_en_i (irq_en_i),
    .conv_en_i(conv_en_i),
    .stat_o   (stat_o),
    .irq_o    (irq_o),
    .conv_o   (conv_start_o)
  );

  // R1: outputs are quiet while the outer reset is held.
  always_comb begin
    if (!rst_ni) a_reset_quiet_r1: assert (stat_o == 2'b00 && !irq_o && !conv_start_o);
  end

endmodule

// File: tb/pen_dbnc_top_tb.sv
module pen_dbnc_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pen_raw;
  logic [3:0] dbnc_exp;
  logic [1:0] irq_en;
  logic       conv_en;
  logic       stat_rd;
  logic [1:0] stat;
  logic       irq;
  logic       conv;

  always #10 clk = ~clk;

  pen_dbnc_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pen_raw_i   (pen_raw),
    .dbnc_exp_i  (dbnc_exp),
    .irq_en_i    (irq_en),
    .conv_en_i   (conv_en),
    .stat_rd_i   (stat_rd),
    .stat_o      (stat),
    .irq_o       (irq),
    .conv_start_o(conv)
  );

  // kinds: 0 pen down, 1 pen up, 2 conversion start
  typedef struct {
    int    kind;
    int    due;
    string tag;
  } item_t;

  item_t      exp_q[$];
  int         cyc = 0;
  int         n_chk = 0;
  int         n_err = 0;
  bit         mon_on = 1'b0;
  logic [1:0] prev_stat = 2'b00;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic push(input int kind, input int due, input string tag);
    item_t it;
    it.kind = kind;
    it.due  = due;
    it.tag  = tag;
    exp_q.push_back(it);
  endtask

  task automatic got(input int kind);
    item_t it;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R2/R3/R8/R10", "unexpected event kind", kind, -1);
    end else begin
      it = exp_q.pop_front();
      chk(it.kind == kind, it.tag, "event kind", kind, it.kind);
      chk(it.due == cyc, it.tag, "event cycle", cyc, it.due);
    end
  endtask

  // Monitor: new status bits and conversion pulses against the queue.
  always @(negedge clk) begin
    if (mon_on) begin
      if (stat[0] && !prev_stat[0]) got(0);
      if (stat[1] && !prev_stat[1]) got(1);
      if (conv) got(2);
    end
    prev_stat = stat;
  end

  task automatic drive(input logic v, output int c);
    @(negedge clk);
    pen_raw = v;
    c = cyc;
  endtask

  task automatic do_read(output logic [1:0] val);
    @(negedge clk);
    stat_rd = 1'b1;
    val = stat;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  function automatic int len(input int n);
    return 1 << n;
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements): actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int c, c2;
    logic [1:0] rv;
    rst_n    = 1'b0;
    pen_raw  = 1'b0;
    dbnc_exp = 4'd2;
    irq_en   = 2'b11;
    conv_en  = 1'b1;
    stat_rd  = 1'b0;

    repeat (3) @(negedge clk);
    chk(stat == 2'b00, "R1", "status in reset", stat, 0);
    chk(irq == 1'b0, "R1", "irq in reset", irq, 0);
    chk(conv == 1'b0, "R1", "conv in reset", conv, 0);
    rst_n = 1'b1;

    // R9: first stable low level after reset reports pen up.
    repeat (20) @(negedge clk);
    chk(stat == 2'b10, "R9", "status after reset", stat, 2);
    chk(irq == 1'b1, "R7", "irq with up bit enabled", irq, 1);
    do_read(rv);
    chk(rv == 2'b10, "R5", "read value", rv, 2);
    chk(stat == 2'b00, "R5", "status after read", stat, 0);
    chk(irq == 1'b0, "R7", "irq after read", irq, 0);
    mon_on = 1'b1;

    // R2/R8: contact with L=4, conversion enabled.
    drive(1'b1, c);
    push(0, c + 4 + len(2), "R2");
    push(2, c + 4 + len(2), "R8");
    repeat (15) @(negedge clk);
    chk(irq == 1'b1, "R7", "irq with down bit", irq, 1);
    do_read(rv);
    chk(rv == 2'b01, "R5", "read value after down", rv, 1);
    chk(stat == 2'b00, "R5", "status cleared", stat, 0);

    // R10: holding contact reports nothing more.
    repeat (20) @(negedge clk);
    chk(stat == 2'b00, "R10", "status while holding", stat, 0);

    // R4: low glitch of exactly L cycles is rejected.
    drive(1'b0, c);
    repeat (len(2) - 1) @(negedge clk);
    drive(1'b1, c2);
    repeat (20) @(negedge clk);
    chk(stat == 2'b00, "R4", "status after glitch", stat, 0);

    // R3/R7: release, up bit masked then enabled.
    irq_en = 2'b01;
    drive(1'b0, c);
    push(1, c + 4 + len(2), "R3");
    repeat (15) @(negedge clk);
    chk(stat == 2'b10, "R3", "up bit set", stat, 2);
    chk(irq == 1'b0, "R7", "irq with up bit masked", irq, 0);
    irq_en = 2'b10;
    @(negedge clk);
    chk(irq == 1'b1, "R7", "irq with up bit enabled", irq, 1);
    do_read(rv);

    // R2 boundary: contact of exactly L+1 cycles is accepted, then release.
    drive(1'b1, c);
    repeat (len(2)) @(negedge clk);
    drive(1'b0, c2);
    push(0, c + 4 + len(2), "R2");
    push(2, c + 4 + len(2), "R8");
    push(1, c2 + 4 + len(2), "R3");
    repeat (20) @(negedge clk);
    chk(stat == 2'b11, "R2", "both bits after short contact", stat, 3);
    do_read(rv);

    // R8: no conversion pulse when routing is off.
    conv_en = 1'b0;
    drive(1'b1, c);
    push(0, c + 4 + len(2), "R8");
    repeat (15) @(negedge clk);

    // R6: read in the cycle that closes on the up event, with L=1.
    dbnc_exp = 4'd0;
    @(negedge clk);
    drive(1'b0, c);
    push(1, c + 4 + len(0), "R6");
    repeat (len(0) + 3) @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk(stat == 2'b10, "R6", "event beats read", stat, 2);
    do_read(rv);

    // R2/R8: long length L=32.
    conv_en  = 1'b1;
    dbnc_exp = 4'd5;
    @(negedge clk);
    drive(1'b1, c);
    push(0, c + 4 + len(5), "R2");
    push(2, c + 4 + len(5), "R8");
    repeat (60) @(negedge clk);
    chk(stat == 2'b01, "R2", "down bit with L=32", stat, 1);

    chk(exp_q.size() == 0, "R2/R3", "pending expected events", exp_q.size(), 0);
    finish_run();
  end

endmodule